// File: doc/BRIEF.md
# Per-Word Lock Guard for One-Time-Programmable Words

This block keeps the access locks for an array of 32-bit one-time-programmable words. It has three sets of lock bits with one bit per word in each set. A read-refresh lock stops a word's shadow copy from being reloaded from the array. A shadow-write lock makes bus writes to that shadow copy have no effect. A program lock stops program commands for that word. A small global lock register sits beside these sets. It can lock programming of the upper region, lock all programming, and lock the debug configuration. All lock bits are write-one-to-set. A written zero does nothing, and only reset clears a lock bit.

The controller that sequences the fuse array sends each intended operation to this block as a request: an operation code and a word index. One cycle later the block answers with exactly one of two single-cycle pulses, grant or deny. A fourth operation code asks whether the non-secure world may read the word. That answer depends on the index limit, the upper-region boundary, and a closed-device flag that is captured while reset is held. Software sets and reads back the locks through a simple register port. The port selects one of the four register kinds and, for the per-word sets, a bank number.

Top module: `otp_word_lock_guard`

## Requirements
- R1: The lock bit for word w lives in bank w/32, bit w%32, of its set. Register select encoding: 0 read-refresh locks, 1 shadow-write locks, 2 program locks, 3 global register. `bus_rdata_o` shows the selected register combinationally.
- R2: Writing 1 to a lock bit sets it. Writing 0 leaves it unchanged. Bits for words at or beyond NUM_WORDS, and banks at or beyond NUM_BANKS, read as 0 and cannot be set.
- R3: A refresh request (op 0) for a word whose read-refresh lock is set is denied. Otherwise it is granted.
- R4: A shadow-write request (op 1) for a word whose shadow-write lock is set is denied.
- R5: A program request (op 2) for a word whose program lock is set is denied.
- R6: The global register has three settable bits. Bit 0 denies programming of words with index ≥ UPPER_BASE. Bit 3 denies all programming. Bit 2 drives `dbg_cfg_lock_o`. Bit 1 and bits 31..4 read as 0. The bits are write-one-to-set.
- R7: A non-secure read query (op 3) is granted only when index ≤ MAX_IDX and either index < UPPER_BASE or the device is not closed.
- R8: Any request with index > MAX_IDX is denied, whatever the operation.
- R9: A request presented at a clock edge produces exactly one of `req_grant_o` and `req_deny_o` during the following cycle. Neither output is high after an edge with no request. A request decided at the same edge as a lock write still sees the old locks.
- R10: Reset clears every lock bit. `closed_cfg_i` is captured on every clock edge while reset is held and kept afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| closed_cfg_i | input | 1 | Closed-device flag, captured while reset is held |
| bus_wr_i | input | 1 | Register write strobe |
| bus_sel_i | input | 2 | Register kind select |
| bus_bank_i | input | BANK_AW (2) | Bank number within a per-word set |
| bus_wdata_i | input | 32 | Write data, ones set bits |
| bus_rdata_o | output | 32 | Read-back of the selected register |
| req_valid_i | input | 1 | Request present |
| req_op_i | input | 2 | Operation code (0 refresh, 1 shadow write, 2 program, 3 non-secure read) |
| req_idx_i | input | IDX_W (7) | Word index |
| req_grant_o | output | 1 | One-cycle grant pulse |
| req_deny_o | output | 1 | One-cycle deny pulse |
| dbg_cfg_lock_o | output | 1 | Debug configuration locked |

## Verification
The assertions assume that `closed_cfg_i` is settled during reset and that reset is held for at least one clock edge. They also assume that the request and bus inputs are stable around each rising edge. The stimulus meets these assumptions by driving every input on the falling edge, by changing the closed flag only while reset is asserted, and by holding reset for three cycles. Requests and bus writes are sometimes issued in the same cycle. This checks that a decision uses the locks from before the write.

// File: rtl/otp_lock_pkg.sv
package otp_lock_pkg;

   localparam int WORD_BITS = 32;

   typedef enum logic [1:0] {
      OP_REFRESH = 2'd0,
      OP_SHWRITE = 2'd1,
      OP_PROGRAM = 2'd2,
      OP_NSREAD  = 2'd3
   } lock_op_e;

   typedef enum logic [1:0] {
      SEL_RDLOCK = 2'd0,
      SEL_WRLOCK = 2'd1,
      SEL_PGLOCK = 2'd2,
      SEL_GLOBAL = 2'd3
   } reg_sel_e;

   // global register bit positions
   localparam int G_UPPER = 0;
   localparam int G_DEBUG = 2;
   localparam int G_PROG  = 3;
   localparam logic [3:0] G_IMPL_MASK = 4'b1101;

endpackage

// File: rtl/otp_lock_bank.sv
module otp_lock_bank #(
   parameter int NUM_WORDS = 96,
   parameter int NUM_BANKS = 3,
   parameter int BANK_AW   = 2,
   parameter int IDX_W     = 7
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en_i,
   input  logic [BANK_AW-1:0] wr_bank_i,
   input  logic [31:0]        wr_data_i,
   input  logic [BANK_AW-1:0] rd_bank_i,
   output logic [31:0]        rd_data_o,
   input  logic [IDX_W-1:0]   chk_idx_i,
   output logic               chk_set_o
);
   import otp_lock_pkg::*;

   localparam int TOTAL_BITS = NUM_BANKS * WORD_BITS;

   logic [31:0]           bits_q [NUM_BANKS];
   logic [TOTAL_BITS-1:0] flat;

   function automatic logic [31:0] impl_mask(int bank);
      logic [31:0] m;
      for (int k = 0; k < WORD_BITS; k++) m[k] = ((bank * WORD_BITS + k) < NUM_WORDS);
      return m;
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int b = 0; b < NUM_BANKS; b++) bits_q[b] <= '0;
      end else begin
         for (int b = 0; b < NUM_BANKS; b++)
            if (wr_en_i && wr_bank_i == BANK_AW'(b))
               bits_q[b] <= bits_q[b] | (wr_data_i & impl_mask(b));
      end
   end

   always_comb begin
      for (int b = 0; b < NUM_BANKS; b++) flat[b*WORD_BITS +: WORD_BITS] = bits_q[b];
   end

   always_comb begin
      rd_data_o = '0;
      for (int b = 0; b < NUM_BANKS; b++)
         if (rd_bank_i == BANK_AW'(b)) rd_data_o = bits_q[b];
   end

   always_comb begin
      chk_set_o = 1'b0;
      for (int w = 0; w < NUM_WORDS; w++)
         if (chk_idx_i == IDX_W'(w)) chk_set_o = flat[w];
   end

   // R2: a set bit never falls outside reset
   a_r2_bits_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (($past(flat) & ~flat) == '0));

   // R2: an all-zero write changes nothing
   a_r2_zero_write_inert: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && wr_data_i == '0) |=> $stable(flat));

endmodule

// File: rtl/otp_global_lock.sv
module otp_global_lock (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_en_i,
   input  logic [3:0] wr_data_i,
   output logic [3:0] bits_o
);
   import otp_lock_pkg::*;

   logic [3:0] g_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       g_q <= '0;
      else if (wr_en_i) g_q <= g_q | (wr_data_i & G_IMPL_MASK);
   end

   assign bits_o = g_q;

   // R6: global bits are sticky
   a_r6_global_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (($past(g_q) & ~g_q) == 4'b0000));

endmodule

// File: rtl/otp_access_judge.sv
module otp_access_judge #(
   parameter int IDX_W      = 7,
   parameter int MAX_IDX    = 95,
   parameter int UPPER_BASE = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid_i,
   input  logic [1:0]       req_op_i,
   input  logic [IDX_W-1:0] req_idx_i,
   input  logic             rd_lock_i,
   input  logic             wr_lock_i,
   input  logic             pg_lock_i,
   input  logic             g_upper_i,
   input  logic             g_prog_i,
   input  logic             closed_i,
   output logic             grant_o,
   output logic             deny_o
);
   import otp_lock_pkg::*;

   logic     in_range, is_upper, allow;
   lock_op_e op;
   logic     grant_q, deny_q;

   assign op       = lock_op_e'(req_op_i);
   assign in_range = int'(req_idx_i) <= MAX_IDX;
   assign is_upper = int'(req_idx_i) >= UPPER_BASE;

   always_comb begin
      unique case (op)
         OP_REFRESH: allow = in_range && !rd_lock_i;
         OP_SHWRITE: allow = in_range && !wr_lock_i;
         OP_PROGRAM: allow = in_range && !pg_lock_i && !g_prog_i && !(g_upper_i && is_upper);
         OP_NSREAD:  allow = in_range && (!is_upper || !closed_i);
         default:    allow = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         grant_q <= 1'b0;
         deny_q  <= 1'b0;
      end else begin
         grant_q <= req_valid_i && allow;
         deny_q  <= req_valid_i && !allow;
      end
   end

   assign grant_o = grant_q;
   assign deny_o  = deny_q;

   // R9: each request gets exactly one outcome
   a_r9_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid_i |=> (grant_q ^ deny_q));

   // R9: no request, no pulse
   a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid_i |=> (!grant_q && !deny_q));

   // R8: out-of-range index always denied
   a_r8_range_deny: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid_i && int'(req_idx_i) > MAX_IDX) |=> deny_q);

endmodule

// File: rtl/otp_word_lock_guard.sv
module otp_word_lock_guard #(
   parameter int NUM_WORDS  = 96,
   parameter int MAX_IDX    = 95,
   parameter int UPPER_BASE = 32,
   localparam int NUM_BANKS = (NUM_WORDS + 31) / 32,
   localparam int BANK_AW   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
   localparam int IDX_W     = $clog2(NUM_WORDS)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               closed_cfg_i,
   input  logic               bus_wr_i,
   input  logic [1:0]         bus_sel_i,
   input  logic [BANK_AW-1:0] bus_bank_i,
   input  logic [31:0]        bus_wdata_i,
   output logic [31:0]        bus_rdata_o,
   input  logic               req_valid_i,
   input  logic [1:0]         req_op_i,
   input  logic [IDX_W-1:0]   req_idx_i,
   output logic               req_grant_o,
   output logic               req_deny_o,
   output logic               dbg_cfg_lock_o
);
   import otp_lock_pkg::*;

   localparam int NUM_SETS = 3;

   if (NUM_WORDS < 2)                            $error("NUM_WORDS must be at least 2");
   if (MAX_IDX < 0 || MAX_IDX >= NUM_WORDS)      $error("MAX_IDX must index an implemented word");
   if (UPPER_BASE < 0 || UPPER_BASE > NUM_WORDS) $error("UPPER_BASE out of range");

   logic [31:0] set_rd [NUM_SETS];
   logic        set_chk [NUM_SETS];
   logic [3:0]  g_bits;
   logic        closed_q;

   // closed-device flag sampled while reset is held
   always_ff @(posedge clk) begin
      if (!rst_n) closed_q <= closed_cfg_i;
   end

   for (genvar k = 0; k < NUM_SETS; k++) begin : g_set
      otp_lock_bank #(
         .NUM_WORDS (NUM_WORDS),
         .NUM_BANKS (NUM_BANKS),
         .BANK_AW   (BANK_AW),
         .IDX_W     (IDX_W)
      ) u_bank (
         .clk       (clk),
         .rst_n     (rst_n),
         .wr_en_i   (bus_wr_i && bus_sel_i == 2'(k)),
         .wr_bank_i (bus_bank_i),
         .wr_data_i (bus_wdata_i),
         .rd_bank_i (bus_bank_i),
         .rd_data_o (set_rd[k]),
         .chk_idx_i (req_idx_i),
         .chk_set_o (set_chk[k])
      );
   end

   otp_global_lock u_global (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en_i   (bus_wr_i && bus_sel_i == SEL_GLOBAL),
      .wr_data_i (bus_wdata_i[3:0]),
      .bits_o    (g_bits)
   );

   always_comb begin
      unique case (reg_sel_e'(bus_sel_i))
         SEL_RDLOCK: bus_rdata_o = set_rd[0];
         SEL_WRLOCK: bus_rdata_o = set_rd[1];
         SEL_PGLOCK: bus_rdata_o = set_rd[2];
         default:    bus_rdata_o = {28'd0, g_bits};
      endcase
   end

   otp_access_judge #(
      .IDX_W      (IDX_W),
      .MAX_IDX    (MAX_IDX),
      .UPPER_BASE (UPPER_BASE)
   ) u_judge (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_valid_i (req_valid_i),
      .req_op_i    (req_op_i),
      .req_idx_i   (req_idx_i),
      .rd_lock_i   (set_chk[0]),
      .wr_lock_i   (set_chk[1]),
      .pg_lock_i   (set_chk[2]),
      .g_upper_i   (g_bits[G_UPPER]),
      .g_prog_i    (g_bits[G_PROG]),
      .closed_i    (closed_q),
      .grant_o     (req_grant_o),
      .deny_o      (req_deny_o)
   );

   assign dbg_cfg_lock_o = g_bits[G_DEBUG];

   // R6: global programming lock denies any program request
   a_r6_prog_global: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid_i && req_op_i == 2'd2 && g_bits[G_PROG]) |=> req_deny_o);

   // R7: closed device refuses non-secure reads of the upper region
   a_r7_ns_upper_closed: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid_i && req_op_i == 2'd3 && int'(req_idx_i) >= UPPER_BASE && closed_q)
      |=> req_deny_o);

endmodule

// File: tb/otp_word_lock_guard_tb.sv
module otp_word_lock_guard_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        closed_cfg = 1'b1;
   logic        bus_wr = 1'b0;
   logic [1:0]  bus_sel = 2'd0;
   logic [1:0]  bus_bank = 2'd0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        req_valid = 1'b0;
   logic [1:0]  req_op = 2'd0;
   logic [6:0]  req_idx = '0;
   logic        req_grant, req_deny, dbg_lock;

   int n_checks = 0;
   int n_fails  = 0;
   bit done     = 1'b0;

   always #2.5 clk = ~clk;

   otp_word_lock_guard u_dut (
      .clk            (clk),
      .rst_n          (rst_n),
      .closed_cfg_i   (closed_cfg),
      .bus_wr_i       (bus_wr),
      .bus_sel_i      (bus_sel),
      .bus_bank_i     (bus_bank),
      .bus_wdata_i    (bus_wdata),
      .bus_rdata_o    (bus_rdata),
      .req_valid_i    (req_valid),
      .req_op_i       (req_op),
      .req_idx_i      (req_idx),
      .req_grant_o    (req_grant),
      .req_deny_o     (req_deny),
      .dbg_cfg_lock_o (dbg_lock)
   );

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   task automatic do_reset(logic closed);
      @(negedge clk);
      rst_n = 1'b0;
      closed_cfg = closed;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic bus_write(logic [1:0] sel, logic [1:0] bank, logic [31:0] data);
      @(negedge clk);
      bus_wr = 1'b1; bus_sel = sel; bus_bank = bank; bus_wdata = data;
      @(negedge clk);
      bus_wr = 1'b0; bus_wdata = '0;
   endtask

   task automatic bus_check(string tag, logic [1:0] sel, logic [1:0] bank, logic [31:0] exp);
      @(negedge clk);
      bus_sel = sel; bus_bank = bank;
      #1;
      check(tag, bus_rdata, exp);
   endtask

   // expect_grant: 1 = grant pulse, 0 = deny pulse
   task automatic request(string tag, logic [1:0] op, int idx, logic expect_grant);
      @(negedge clk);
      req_valid = 1'b1; req_op = op; req_idx = 7'(idx);
      @(negedge clk);
      req_valid = 1'b0;
      check(tag, {30'd0, req_grant, req_deny}, {30'd0, expect_grant, ~expect_grant});
   endtask

   task automatic t_reset_state;
      bus_check("R10 rdlock bank0 after reset", 2'd0, 2'd0, 32'h0);
      bus_check("R10 pglock bank2 after reset", 2'd2, 2'd2, 32'h0);
      bus_check("R10 global after reset",       2'd3, 2'd0, 32'h0);
      check("R10 no pulses after reset", {30'd0, req_grant, req_deny}, 32'h0);
      check("R6 debug lock low after reset", {31'd0, dbg_lock}, 32'h0);
   endtask

   task automatic t_mapping;
      bus_write(2'd0, 2'd1, 32'h0000_0020);               // word 37
      bus_check("R1 rdlock bank1 holds bit5", 2'd0, 2'd1, 32'h0000_0020);
      bus_check("R1 rdlock bank0 untouched",  2'd0, 2'd0, 32'h0);
      bus_check("R1 wrlock bank1 untouched",  2'd1, 2'd1, 32'h0);
      request("R3 refresh word37 locked",  2'd0, 37, 1'b0);
      request("R3 refresh word36 free",    2'd0, 36, 1'b1);
      request("R3 refresh word5 free",     2'd0, 5,  1'b1);
   endtask

   task automatic t_set_only;
      bus_write(2'd0, 2'd1, 32'h0);
      bus_check("R2 zero write keeps bit", 2'd0, 2'd1, 32'h0000_0020);
      bus_write(2'd0, 2'd1, 32'h0000_0001);
      bus_check("R2 second set accumulates", 2'd0, 2'd1, 32'h0000_0021);
      bus_write(2'd0, 2'd3, 32'hFFFF_FFFF);
      bus_check("R2 bank past end reads zero", 2'd0, 2'd3, 32'h0);
      request("R2 refresh word32 locked", 2'd0, 32, 1'b0);
   endtask

   task automatic t_shadow_write;
      bus_write(2'd1, 2'd0, 32'h0000_0001);               // word 0
      request("R4 shadow write word0 locked", 2'd1, 0,  1'b0);
      request("R4 shadow write word37 free",  2'd1, 37, 1'b1);
      request("R4 refresh word0 unaffected",  2'd0, 0,  1'b1);
   endtask

   task automatic t_program;
      bus_write(2'd2, 2'd2, 32'h8000_0000);               // word 95
      request("R5 program word95 locked", 2'd2, 95, 1'b0);
      request("R5 program word94 free",   2'd2, 94, 1'b1);
   endtask

   task automatic t_timing;
      @(negedge clk);
      bus_wr = 1'b1; bus_sel = 2'd2; bus_bank = 2'd0; bus_wdata = 32'h0000_0800;   // word 11
      req_valid = 1'b1; req_op = 2'd2; req_idx = 7'd11;
      @(negedge clk);
      bus_wr = 1'b0; bus_wdata = '0;
      check("R9 same-edge request sees old lock", {30'd0, req_grant, req_deny}, 32'h2);
      @(negedge clk);
      req_valid = 1'b0;
      check("R9 next request sees new lock", {30'd0, req_grant, req_deny}, 32'h1);
      @(negedge clk);
      check("R9 idle gives no pulse", {30'd0, req_grant, req_deny}, 32'h0);
   endtask

   task automatic t_range;
      request("R8 refresh index 100", 2'd0, 100, 1'b0);
      request("R8 shadow write index 127", 2'd1, 127, 1'b0);
      request("R8 program index 96", 2'd2, 96, 1'b0);
   endtask

   task automatic t_nonsecure_closed;
      request("R7 closed lower word", 2'd3, 10, 1'b1);
      request("R7 closed upper word", 2'd3, 40, 1'b0);
      request("R7 closed out of range", 2'd3, 100, 1'b0);
   endtask

   task automatic t_global;
      bus_write(2'd3, 2'd0, 32'h0000_0001);
      bus_check("R6 global upper bit", 2'd3, 2'd0, 32'h1);
      request("R6 upper lock denies word40", 2'd2, 40, 1'b0);
      request("R6 upper lock spares word20", 2'd2, 20, 1'b1);
      bus_write(2'd3, 2'd0, 32'hFFFF_FFFF);
      bus_check("R6 unimplemented global bits zero", 2'd3, 2'd0, 32'hD);
      check("R6 debug lock output", {31'd0, dbg_lock}, 32'h1);
      request("R6 program lock denies word20", 2'd2, 20, 1'b0);
      request("R6 refresh unaffected by global", 2'd0, 20, 1'b1);
      bus_write(2'd3, 2'd0, 32'h0);
      bus_check("R6 global zero write inert", 2'd3, 2'd0, 32'hD);
   endtask

   task automatic t_reopen;
      do_reset(1'b0);
      bus_check("R10 rdlock bank1 cleared", 2'd0, 2'd1, 32'h0);
      bus_check("R10 global cleared",       2'd3, 2'd0, 32'h0);
      request("R10 refresh word37 after reset", 2'd0, 37, 1'b1);
      request("R7 open device upper word", 2'd3, 40, 1'b1);
      request("R7 open device max word",   2'd3, 95, 1'b1);
      request("R7 open device past max",   2'd3, 96, 1'b0);
   endtask

   task automatic finish_run;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   endtask

   initial begin
      do_reset(1'b1);
      t_reset_state();
      t_mapping();
      t_set_only();
      t_shadow_write();
      t_program();
      t_timing();
      t_range();
      t_nonsecure_closed();
      t_global();
      t_reopen();
      done = 1'b1;
      finish_run();
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         finish_run();
      end
   end

endmodule